// File: doc/BRIEF.md
# Deficit-Idle Byte-to-Word Aligner

This block accepts one byte-wide code per clock, carried as an enable flag, an error flag and an 8-bit value, in the manner of a full-duplex byte interface without carrier sense or collision. It packs these codes into four-lane words, where each lane carries an 8-bit value and a control flag. The words are then handed to a 32-bit lane group. While packing, the block translates each byte into a lane code. It also makes sure that certain bytes always land on lane 0 of a word: the first byte of a frame, the first low-power-idle byte that follows an idle, and the marker byte that opens an ordered set.

When one of these bytes would otherwise fall on lane 1, 2 or 3, the idle bytes waiting ahead of it are either dropped or padded out with extra idles. A deficit counter, held between 0 and 3, picks between the two. Dropping idles raises the deficit and padding lowers it, so over time the idle spacing between frames averages out. The block never removes or adds any byte other than an idle.

A byte is taken on every rising clock edge. A word is presented for one cycle, with a valid strobe, in the cycle after the edge that completes it. Rate matching and clock-domain crossing are left to the surrounding logic.

Top module: `dic_aligner`

## Requirements
- R1: While reset is low and after it is released, the valid strobe is low and the deficit is 0. Packing then starts at lane 0.
- R2: Bytes fill lanes 0,1,2,3 in arrival order. The valid strobe rises for exactly one cycle, after the edge that takes the byte completing a word. Lane n occupies out_d[8n+7:8n] and its control flag is out_c[n].
- R3: Each input byte maps to one lane code, and every control code has its lane flag set to 1:
  - enable=1, error=0: data, with flag 0 and the value passed through.
  - enable=1, error=1: control 0xFE.
  - enable=0, error=0: idle, control 0x07.
  - enable=0, error=1, value 0x01: low-power idle, control 0x06.
  - enable=0, error=1, value 0x9C: ordered-set marker, control 0x9C.
  - enable=0, error=1, any other value: control 0xFE.
  - The first enabled byte after a non-enabled byte is a start, control 0xFB, unless the byte before it was an ordered-set marker. Its value is replaced.
  - The first idle after a frame becomes terminate, control 0xFD.
- R4: A start control (0xFB) only ever appears on lane 0.
- R5: When an aligning byte would land on lane L>0, the pending idles are deleted if two conditions hold: every pending byte is a plain idle (0x07), and deficit+L is at most 3. The aligning byte then goes on lane 0, the deficit rises by L, and no word is emitted on that edge.
- R6: Otherwise the pending bytes are completed with 4−L idles and emitted as a word on that edge. The aligning byte goes on lane 0 of the next word, and the deficit falls by 4−L, saturating at 0.
- R7: A low-power-idle byte is aligned only when the byte before it was an idle. A low-power idle that follows any other byte is packed in place.
- R8: An ordered-set marker that follows an idle is aligned to lane 0. Enabled bytes that directly follow a marker are data, not starts. An idle that follows such data is a plain idle, not a terminate.
- R9: A pending terminate or any other non-idle byte is never deleted. When one is pending, the block pads with idles even at deficit 0, and the deficit stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one byte taken per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_en | input | 1 | Byte enable (frame or ordered-set data) |
| in_er | input | 1 | Byte error / control qualifier |
| in_d | input | 8 | Byte value |
| out_vld | output | 1 | One-cycle strobe: word on out_d/out_c is valid |
| out_d | output | 32 | Four lane values, lane 0 in bits 7:0 |
| out_c | output | 4 | Lane control flags, bit n for lane n |

## Verification
A word is due one edge after the byte that completes it is taken. The same holds for the padded word emitted on the edge that takes an aligning byte. A deletion emits nothing on its edge, so it shows up only as a missing word and a shifted next word. The bench drives each byte on a falling edge and samples the outputs on the following falling edge, which is after the one register stage. It logs every strobed word, so each scenario can check exact word contents and the exact word count. Deficit values that cannot be seen directly are inferred from whether a later misaligned start causes a drop or a pad.

// File: rtl/dic_aligner.sv
module dic_aligner (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_en,
  input  logic        in_er,
  input  logic [7:0]  in_d,
  output logic        out_vld,
  output logic [31:0] out_d,
  output logic [3:0]  out_c
);
  localparam logic [7:0] C_IDLE = 8'h07;
  localparam logic [7:0] C_LPI  = 8'h06;
  localparam logic [7:0] C_SEQ  = 8'h9C;
  localparam logic [7:0] C_SOP  = 8'hFB;
  localparam logic [7:0] C_EOP  = 8'hFD;
  localparam logic [7:0] C_ERR  = 8'hFE;
  localparam logic [7:0] V_LPI  = 8'h01;
  localparam logic [7:0] V_SEQ  = 8'h9C;
  localparam int         LANES  = 4;
  localparam int         PEND   = LANES - 1;
  localparam logic [2:0] DMAX   = 3'd3;

  logic [7:0]      pd [PEND];
  logic [PEND-1:0] pc;
  logic [1:0]      cnt;
  logic [1:0]      dic;
  logic            in_frame, prev_idle, prev_seq;

  logic            is_start, is_lpi, is_seq, align, all_idle;
  logic            do_al, del, ins, emit;
  logic [7:0]      cd;
  logic            cc;
  logic [2:0]      sum, pad;
  logic [1:0]      dic_ins;
  logic [31:0]     wd;
  logic [3:0]      wc;

  assign is_start = in_en && !in_frame && !prev_seq;
  assign is_lpi   = !in_en && in_er && (in_d == V_LPI);
  assign is_seq   = !in_en && in_er && (in_d == V_SEQ);
  assign align    = is_start || ((is_lpi || is_seq) && prev_idle);

  always_comb begin
    cc = 1'b1;
    cd = C_ERR;
    if (in_en) begin
      if (is_start)   cd = C_SOP;
      else if (in_er) cd = C_ERR;
      else begin
        cc = 1'b0;
        cd = in_d;
      end
    end else if (!in_er) cd = in_frame ? C_EOP : C_IDLE;
    else if (is_lpi)     cd = C_LPI;
    else if (is_seq)     cd = C_SEQ;
  end

  always_comb begin
    all_idle = 1'b1;
    for (int i = 0; i < PEND; i++)
      if (i < int'(cnt) && !(pc[i] && pd[i] == C_IDLE)) all_idle = 1'b0;
  end

  assign sum     = {1'b0, dic} + {1'b0, cnt};
  assign pad     = 3'd4 - {1'b0, cnt};
  assign dic_ins = ({1'b0, dic} >= pad) ? 2'({1'b0, dic} - pad) : 2'd0;
  assign do_al   = align && (cnt != 2'd0);
  assign del     = do_al && all_idle && (sum <= DMAX);
  assign ins     = do_al && !del;
  assign emit    = ins || (!do_al && cnt == 2'd3);

  always_comb begin
    for (int i = 0; i < PEND; i++) begin
      if (i < int'(cnt)) begin
        wd[8*i +: 8] = pd[i];
        wc[i]        = pc[i];
      end else begin
        wd[8*i +: 8] = C_IDLE;
        wc[i]        = 1'b1;
      end
    end
    if (ins) begin
      wd[31:24] = C_IDLE;
      wc[3]     = 1'b1;
    end else begin
      wd[31:24] = cd;
      wc[3]     = cc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      dic       <= '0;
      in_frame  <= 1'b0;
      prev_idle <= 1'b1;
      prev_seq  <= 1'b0;
      pc        <= '0;
      out_vld   <= 1'b0;
      out_d     <= '0;
      out_c     <= '0;
      for (int i = 0; i < PEND; i++) pd[i] <= '0;
    end else begin
      in_frame  <= in_en && (in_frame || is_start);
      prev_idle <= !in_en && !in_er;
      prev_seq  <= is_seq;
      out_vld   <= emit;
      if (emit) begin
        out_d <= wd;
        out_c <= wc;
      end
      if (do_al) begin
        pd[0] <= cd;
        pc[0] <= cc;
        cnt   <= 2'd1;
        dic   <= del ? sum[1:0] : dic_ins;
      end else if (cnt == 2'd3) begin
        cnt <= 2'd0;
      end else begin
        pd[cnt] <= cd;
        pc[cnt] <= cc;
        cnt     <= cnt + 2'd1;
      end
    end
  end
endmodule

// File: rtl/dic_aligner_chk.sv
module dic_aligner_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        out_vld,
  input logic [31:0] out_d,
  input logic [3:0]  out_c,
  input logic [1:0]  dic
);
  genvar k;
  generate
    for (k = 1; k < 4; k++) begin : g_lane
      p_start_lane0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> !(out_c[k] && out_d[8*k +: 8] == 8'hFB));
      p_lpi_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_c[k] && out_d[8*k +: 8] == 8'h06)
          |-> !(out_c[k-1] && out_d[8*(k-1) +: 8] == 8'h07));
      p_seq_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_c[k] && out_d[8*k +: 8] == 8'h9C)
          |-> !(out_c[k-1] && out_d[8*(k-1) +: 8] == 8'h07));
    end
  endgenerate

  p_del_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dic > $past(dic)) |-> !out_vld);
  p_ins_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dic < $past(dic)) |-> out_vld);
  p_vld_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |=> !out_vld);
endmodule

bind dic_aligner dic_aligner_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_vld(out_vld),
  .out_d(out_d), .out_c(out_c), .dic(dic)
);

// File: tb/sim_dic_aligner.sv
module sim_dic_aligner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_en = 1'b0, in_er = 1'b0;
  logic [7:0]  in_d = '0;
  logic        out_vld;
  logic [31:0] out_d;
  logic [3:0]  out_c;

  int errors = 0, checks = 0, wcnt = 0;
  bit done = 0;
  logic [31:0] wl_d [64];
  logic [3:0]  wl_c [64];

  always #10 clk = ~clk;

  dic_aligner u0 (.clk(clk), .rst_n(rst_n), .in_en(in_en), .in_er(in_er),
                  .in_d(in_d), .out_vld(out_vld), .out_d(out_d), .out_c(out_c));

  task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_en = 0; in_er = 0; in_d = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    wcnt = 0;
  endtask

  task automatic put(input logic e, input logic r, input logic [7:0] d);
    in_en = e; in_er = r; in_d = d;
    @(negedge clk);
    if (out_vld && wcnt < 64) begin
      wl_d[wcnt] = out_d;
      wl_c[wcnt] = out_c;
      wcnt++;
    end
  endtask

  task automatic idle(); put(0, 0, 8'h00); endtask
  task automatic sop();  put(1, 0, 8'h55); endtask
  task automatic dat(input logic [7:0] v); put(1, 0, v); endtask
  task automatic lpi();  put(0, 1, 8'h01); endtask
  task automatic seq();  put(0, 1, 8'h9C); endtask

  task automatic chkw(input int i, input logic [31:0] ed, input logic [3:0] ec, input string req);
    check(wl_d[i] == ed && wl_c[i] == ec, req, {wl_c[i], wl_d[i]}, {ec, ed});
  endtask

  task automatic chkn(input int n, input string req);
    check(wcnt == n, req, 36'(wcnt), 36'(n));
  endtask

  task automatic t_reset_pack();
    do_reset();
    check(out_vld == 1'b0, "R1", 36'(out_vld), 36'd0);
    idle(); idle(); idle();
    check(out_vld == 1'b0, "R2", 36'(out_vld), 36'd0);
    idle();
    check(out_vld == 1'b1, "R2", 36'(out_vld), 36'd1);
    chkw(0, 32'h07070707, 4'b1111, "R2");
    idle();
    check(out_vld == 1'b0, "R2", 36'(out_vld), 36'd0);
  endtask

  task automatic t_delete_then_insert();
    do_reset();
    idle(); sop(); dat(8'h11); dat(8'h22); dat(8'h33);
    dat(8'h44); dat(8'h55); dat(8'h66); idle();
    idle(); idle(); idle(); sop(); dat(8'h11); dat(8'h22); dat(8'h33);
    chkw(0, 32'h332211FB, 4'b0001, "R5");
    chkw(1, 32'hFD665544, 4'b1000, "R3");
    chkw(2, 32'h07070707, 4'b1111, "R6");
    chkw(3, 32'h332211FB, 4'b0001, "R4");
    chkn(4, "R6");
  endtask

  task automatic t_deficit2();
    do_reset();
    idle(); idle(); sop(); dat(8'hA1); dat(8'hA2); dat(8'hA3);
    dat(8'hA4); dat(8'hA5); idle(); idle();
    idle(); idle(); sop(); dat(8'hB1); dat(8'hB2); dat(8'hB3);
    chkw(0, 32'hA3A2A1FB, 4'b0001, "R5");
    chkw(1, 32'h07FDA5A4, 4'b1100, "R3");
    chkw(2, 32'h07070707, 4'b1111, "R6");
    chkw(3, 32'hB3B2B1FB, 4'b0001, "R6");
    chkn(4, "R5");
  endtask

  task automatic t_keep_nonidle();
    do_reset();
    sop(); dat(8'hC1); dat(8'hC2); dat(8'hC3);
    dat(8'hC4); idle(); sop(); dat(8'hD1); dat(8'hD2); dat(8'hD3);
    chkw(0, 32'hC3C2C1FB, 4'b0001, "R9");
    chkw(1, 32'h0707FDC4, 4'b1110, "R9");
    chkw(2, 32'hD3D2D1FB, 4'b0001, "R9");
    chkn(3, "R9");
  endtask

  task automatic t_lpi();
    do_reset();
    idle();
    for (int i = 0; i < 8; i++) lpi();
    idle(); idle(); idle(); idle();
    sop(); dat(8'hE1); dat(8'hE2); lpi();
    chkw(0, 32'h06060606, 4'b1111, "R7");
    chkw(1, 32'h06060606, 4'b1111, "R7");
    chkw(3, 32'h06E2E1FB, 4'b1001, "R7");
    chkn(4, "R7");
  endtask

  task automatic t_ordered_set();
    do_reset();
    idle(); idle(); idle(); seq();
    dat(8'h10); seq(); dat(8'h91); seq(); dat(8'h92); seq(); dat(8'h13);
    idle(); idle(); idle(); idle();
    idle(); sop(); dat(8'hF1); dat(8'hF2); dat(8'hF3);
    chkw(0, 32'h919C109C, 4'b0101, "R8");
    chkw(1, 32'h139C929C, 4'b0101, "R8");
    chkw(2, 32'h07070707, 4'b1111, "R8");
    chkw(3, 32'h07070707, 4'b1111, "R6");
    chkw(4, 32'hF3F2F1FB, 4'b0001, "R6");
    chkn(5, "R8");
  endtask

  task automatic t_errors();
    do_reset();
    sop(); put(1, 1, 8'h33); dat(8'h5A); put(0, 1, 8'h0F);
    chkw(0, 32'hFE5AFEFB, 4'b1011, "R3");
    chkn(1, "R3");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset_pack();
    t_delete_then_insert();
    t_deficit2();
    t_keep_nonidle();
    t_lpi();
    t_ordered_set();
    t_errors();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule